// File: doc/BRIEF.md
# Registered Bitwise Function Unit

This block applies one of eight bitwise logic functions to two equal-width operand vectors and captures the outcome in an accumulator register. A 3-bit operation code selects the function. Its upper two bits pick one of four base functions: pass the first operand, AND, OR or XOR. Its lowest bit complements that base result. Because of this pairing, every bit carries one shared inversion stage instead of eight separate function networks.

The datapath is one single-bit slice, replicated once per bit position by a generate loop. No signal passes between bit positions. The accumulator loads the slice outputs on a rising clock edge while the load enable is high, and holds its value otherwise. A synchronous reset clears the accumulator. The accumulator is the only driver of the result output, so results appear one clock after the load edge.

Top module: `bitwise_fn_unit`

## Requirements
- R1: With code 3'b000 the accumulator loads `opnd_a` unchanged. With code 3'b001 it loads the bitwise complement of `opnd_a`. `opnd_b` has no effect on either result.
- R2: Code 3'b010 loads `opnd_a & opnd_b`. Code 3'b011 loads `~(opnd_a & opnd_b)`.
- R3: Code 3'b100 loads `opnd_a | opnd_b`. Code 3'b101 loads `~(opnd_a | opnd_b)`.
- R4: Code 3'b110 loads `opnd_a ^ opnd_b`. Code 3'b111 loads `~(opnd_a ^ opnd_b)`.
- R5: On a rising edge with `rst` low and `load_en` low, `acc_q` keeps its value whatever the code and operands are.
- R6: On a rising edge with `rst` high, `acc_q` becomes all zeros. This holds even when `load_en` is high.
- R7: `acc_q` changes only at a rising clock edge. After a load edge it shows the function of the code and operands sampled at that edge, and it does not change before that edge.
- R8: Bit i of the loaded result depends only on bit i of each operand. A change in one operand bit alters at most that one result bit.
- R9: For the same operands, a code with bit 0 set loads the exact bitwise complement of the value that the same code with bit 0 clear would load.
- R10: The width is the parameter `WIDTH`, with a default of 4 and a minimum of 1. Each bit position is one instance of the same slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear of the accumulator |
| load_en | input | 1 | When high, the function result is loaded at the clock edge |
| op_code | input | 3 | Function select: bits [2:1] pick the base function, bit 0 complements it |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand (unused by the pass functions) |
| acc_q | output | WIDTH | Accumulator contents |

## Verification
A wrong decode of the base-function bits appears at `acc_q` one clock after the first load with the affected code. It shows as the wrong function across all bits, so an operand pair that separates AND, OR, XOR and pass exposes it at once. A faulty inversion stage makes the paired codes differ from exact complements. A leak between slices shows as a flipped neighbour bit when a single operand bit is toggled. A broken hold or reset path shows as `acc_q` changing on an edge where it must not, and it stays wrong until the next correct load.

// File: rtl/lfu_pkg.sv
package lfu_pkg;

   localparam int unsigned CODE_W = 3;

   typedef enum logic [1:0] {
      BASE_PASS = 2'b00,
      BASE_AND  = 2'b01,
      BASE_OR   = 2'b10,
      BASE_XOR  = 2'b11
   } base_fn_e;

   typedef struct packed {
      base_fn_e fn;
      logic     invert;
   } fn_ctrl_t;

endpackage

// File: rtl/lfu_decode.sv
module lfu_decode
   import lfu_pkg::*;
(
   input  logic [CODE_W-1:0] code_i,
   output fn_ctrl_t          ctrl_o
);

   // upper field selects the base function, lowest bit requests complement
   always_comb begin
      ctrl_o.fn     = base_fn_e'(code_i[CODE_W-1:1]);
      ctrl_o.invert = code_i[0];
   end

endmodule

// File: rtl/lfu_bit_slice.sv
module lfu_bit_slice
   import lfu_pkg::*;
(
   input  logic     a_i,
   input  logic     b_i,
   input  fn_ctrl_t ctrl_i,
   output logic     base_o,
   output logic     res_o
);

   always_comb begin
      unique case (ctrl_i.fn)
         BASE_PASS: base_o = a_i;
         BASE_AND:  base_o = a_i & b_i;
         BASE_OR:   base_o = a_i | b_i;
         BASE_XOR:  base_o = a_i ^ b_i;
         default:   base_o = a_i;
      endcase
   end

   // single shared complement stage for both members of a function pair
   assign res_o = base_o ^ ctrl_i.invert;

endmodule

// File: rtl/lfu_acc_reg.sv
module lfu_acc_reg #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_en,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   always_ff @(posedge clk) begin
      if (rst)
         q_o <= '0;
      else if (load_en)
         q_o <= d_i;
   end

   // R6
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (q_o == '0));

   // R5
   hold_value_chk: assert property (@(posedge clk) disable iff (rst)
      !load_en |=> $stable(q_o));

   // R7
   load_latency_chk: assert property (@(posedge clk) disable iff (rst)
      load_en |=> (q_o == $past(d_i)));

endmodule

// File: rtl/bitwise_fn_unit.sv
module bitwise_fn_unit
   import lfu_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_en,
   input  logic [CODE_W-1:0] op_code,
   input  logic [WIDTH-1:0]  opnd_a,
   input  logic [WIDTH-1:0]  opnd_b,
   output logic [WIDTH-1:0]  acc_q
);

   localparam int unsigned MSB = WIDTH - 1;

   // R10
   if (WIDTH < 1) begin : g_width_bad
      $error("bitwise_fn_unit: WIDTH must be at least 1");
   end

   fn_ctrl_t         ctrl;
   logic [MSB:0]     base_vec;
   logic [MSB:0]     next_vec;

   lfu_decode u_decode (
      .code_i (op_code),
      .ctrl_o (ctrl)
   );

   for (genvar gi = 0; gi < WIDTH; gi++) begin : g_slice
      lfu_bit_slice u_slice (
         .a_i    (opnd_a[gi]),
         .b_i    (opnd_b[gi]),
         .ctrl_i (ctrl),
         .base_o (base_vec[gi]),
         .res_o  (next_vec[gi])
      );
   end

   lfu_acc_reg #(
      .WIDTH (WIDTH)
   ) u_acc (
      .clk     (clk),
      .rst     (rst),
      .load_en (load_en),
      .d_i     (next_vec),
      .q_o     (acc_q)
   );

   // R1
   pass_a_chk: assert property (@(posedge clk) disable iff (rst)
      (load_en && op_code == 3'b000) |=> (acc_q == $past(opnd_a)));

   // R1
   inv_a_chk: assert property (@(posedge clk) disable iff (rst)
      (load_en && op_code == 3'b001) |=> (acc_q == ~$past(opnd_a)));

   // R2
   and_fn_chk: assert property (@(posedge clk) disable iff (rst)
      (load_en && op_code == 3'b010) |=> (acc_q == $past(opnd_a & opnd_b)));

   // R3
   or_fn_chk: assert property (@(posedge clk) disable iff (rst)
      (load_en && op_code == 3'b100) |=> (acc_q == $past(opnd_a | opnd_b)));

   // R4
   xor_fn_chk: assert property (@(posedge clk) disable iff (rst)
      (load_en && op_code == 3'b110) |=> (acc_q == $past(opnd_a ^ opnd_b)));

   // R9
   pair_invert_chk: assert property (@(posedge clk) disable iff (rst)
      (load_en && op_code[0]) |=> (acc_q == ~$past(base_vec)));

endmodule

// File: tb/bitwise_fn_unit_tb_top.sv
`timescale 1ns/1ps
module bitwise_fn_unit_tb_top;

   localparam int unsigned W = 4;
   localparam logic [W-1:0] MASK = '1;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         load_en = 1'b0;
   logic [2:0]   op_code = 3'b000;
   logic [W-1:0] opnd_a = '0;
   logic [W-1:0] opnd_b = '0;
   logic [W-1:0] acc_q;

   logic [W-1:0] exp_acc = '0;
   int           n_tests = 0;
   int           n_fail = 0;
   bit           done = 1'b0;

   always #10 clk = ~clk;

   bitwise_fn_unit #(.WIDTH(W)) dut_i (
      .clk     (clk),
      .rst     (rst),
      .load_en (load_en),
      .op_code (op_code),
      .opnd_a  (opnd_a),
      .opnd_b  (opnd_b),
      .acc_q   (acc_q)
   );

   function automatic logic [W-1:0] ref_fn(input logic [2:0] c,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] b);
      logic [W-1:0] r;
      case (c[2:1])
         2'b00:   r = a;
         2'b01:   r = a & b;
         2'b10:   r = a | b;
         default: r = a ^ b;
      endcase
      return c[0] ? ~r : r;
   endfunction

   function automatic string tag_for(input logic r, input logic ld, input logic [2:0] c);
      if (r) return "R6";
      if (!ld) return "R5";
      case (c[2:1])
         2'b00:   return "R1";
         2'b01:   return "R2";
         2'b10:   return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: acc_q=%b expected=%b", tag, act, exp);
      end
   endtask

   // called at a falling edge; drives, clocks once, checks at the next falling edge
   task automatic step(input logic r, input logic ld, input logic [2:0] c,
                       input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
      string t;
      rst = r; load_en = ld; op_code = c; opnd_a = a; opnd_b = b;
      @(posedge clk);
      if (r) exp_acc = '0;
      else if (ld) exp_acc = ref_fn(c, a, b);
      @(negedge clk);
      t = (tag == "") ? tag_for(r, ld, c) : tag;
      check(t, acc_q, exp_acc);
   endtask

   initial begin
      logic [W-1:0] keep;
      logic [W-1:0] ra, rb;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // R6 reset state
      check("R6", acc_q, '0);

      // directed: every code on an operand pair that separates all functions (R1..R4)
      for (int c = 0; c < 8; c++)
         step(1'b0, 1'b1, 3'(c), 4'b1100, 4'b1010, "");

      // R1: opnd_b ignored for pass and complement
      step(1'b0, 1'b1, 3'b000, 4'b0110, 4'b0000, "R1");
      step(1'b0, 1'b1, 3'b000, 4'b0110, 4'b1111, "R1");
      step(1'b0, 1'b1, 3'b001, 4'b0110, 4'b1011, "R1");

      // R5: hold with load low under changing inputs
      keep = acc_q;
      for (int i = 0; i < 6; i++)
         step(1'b0, 1'b0, 3'($urandom), 4'($urandom), 4'($urandom), "R5");
      check("R5", acc_q, keep);

      // R6: reset beats load
      step(1'b0, 1'b1, 3'b001, 4'b0000, 4'b0000, "R1");
      step(1'b1, 1'b1, 3'b001, 4'b0000, 4'b0000, "R6");

      // R7: no change before the edge, new value after
      rst = 1'b0; load_en = 1'b1; op_code = 3'b100; opnd_a = 4'b0101; opnd_b = 4'b0011;
      #5;
      check("R7", acc_q, 4'b0000);
      @(posedge clk);
      exp_acc = 4'b0111;
      #2;
      check("R7", acc_q, 4'b0111);
      @(negedge clk);

      // R8: single-bit flips touch only one result bit
      step(1'b0, 1'b1, 3'b110, 4'b0000, 4'b0000, "R8");
      step(1'b0, 1'b1, 3'b110, 4'b0100, 4'b0000, "R8");
      step(1'b0, 1'b1, 3'b010, 4'b1111, 4'b1110, "R8");
      step(1'b0, 1'b1, 3'b101, 4'b0000, 4'b1000, "R8");

      // R9: paired codes give exact complements
      for (int i = 0; i < 16; i++) begin
         logic [2:0] c;
         c = {2'($urandom), 1'b0};
         ra = 4'($urandom); rb = 4'($urandom);
         step(1'b0, 1'b1, c, ra, rb, "");
         keep = acc_q;
         step(1'b0, 1'b1, c | 3'b001, ra, rb, "");
         check("R9", acc_q, ~keep);
      end

      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         logic r, ld;
         r  = ($urandom % 20) == 0;
         ld = ($urandom % 4) != 0;
         step(r, ld, 3'($urandom), 4'($urandom) & MASK, 4'($urandom) & MASK, "");
      end

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule